// File: doc/BRIEF.md
# Delay-Line Tap Controller for a Digital Clock Deskew Loop

This block is the control engine of a digital delay-locked loop. It picks one of 256 taps on a delay line so that the clock coming back through the clock tree lines up with the incoming reference. A phase detector sends it a comparison result, which is a strobe plus a two-bit code. The engine walks the tap index toward alignment. It declares lock once the comparisons have stayed inside the alignment window for several samples in a row.

Once locked, the engine keeps correcting for slow voltage and temperature drift. It does not act on every comparison. An update is allowed only after a programmable number of clock cycles, and each update moves the tap by at most one step. Two comparison sources are provided, one for each feedback option: the 1x clock or the 2x clock. A select input picks which one is used.

If tracking drives the tap index onto either end of the line, the loop has no margin left. Lock drops, a range error is raised, and everything stays frozen until reset. Logic downstream must treat the clock as unusable whenever `locked` is low.

Top module: `dll_ctrl`

## Requirements
- R1: While `rst` is high at a rising clock edge, the edge leaves `tap` = 0, `locked` = 0 and `range_err` = 0, and acquisition restarts.
- R2: `fb_sel` = 0 takes the comparison from `pd_code_1x` and `fb_sel` = 1 takes it from `pd_code_2x`. Code 2'b01 means the feedback is early and 2'b10 means it is late. Codes 2'b00 and 2'b11 both mean it is within the one-tap window. Nothing happens in a cycle where `pd_valid` is low, and the unselected code is never used.
- R3: During acquisition, a valid early comparison raises `tap` by one on that edge, and a valid late comparison lowers it by one. The index saturates at 0 and at 255 and never raises an error while acquiring.
- R4: `locked` rises on the edge that takes in the 4th consecutive valid within-window comparison during acquisition. Any valid early or late comparison restarts the count.
- R5: `locked` is low throughout acquisition and after a range error.
- R6: While locked, a comparison is applied only when at least `cfg_interval` cycles have passed since lock or since the last applied update. An applied comparison moves `tap` by one step at most, and an applied within-window result leaves it unchanged. Applying any comparison restarts the interval.
- R7: While locked, `tap` does not change in any cycle before the interval has elapsed, whatever the comparisons say.
- R8: While locked, if an applied early comparison finds `tap` ≥ 254, or an applied late comparison finds `tap` ≤ 1, the tap still moves where it can. On that same edge `locked` falls and `range_err` rises. After that, `tap`, `locked` and `range_err` stay frozen until reset.
- R9: A reset after a range error brings back full acquisition and lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| fb_sel | input | 1 | Feedback source: 0 = 1x clock, 1 = 2x clock |
| pd_valid | input | 1 | A phase comparison result is present this cycle |
| pd_code_1x | input | 2 | Comparison code for the 1x feedback path |
| pd_code_2x | input | 2 | Comparison code for the 2x feedback path |
| cfg_interval | input | 16 | Minimum cycles between tracking updates |
| tap | output | 8 | Selected delay-line tap index |
| locked | output | 1 | Feedback aligned; output clock usable |
| range_err | output | 1 | Tap range exhausted during tracking |

## Verification
The interesting collision is a tracking step and the loss of lock landing on the same edge. In that case the tap moves onto a limit while `locked` falls and `range_err` rises. The bench provokes this twice, using a behavioural delay-line model whose required delay drifts step by step. One run drifts down toward tap 0 on the 2x path. The other pushes up to tap 255 with a zero interval on the 1x path. A cycle-accurate reference model is compared on every clock, so the edge on which the tap, the lock flag and the error flag change together is checked exactly, along with the frozen state that follows.

// File: rtl/dllc_pkg.sv
`timescale 1ns/1ps
package dllc_pkg;

    typedef enum logic [1:0] {
        ST_ACQ   = 2'd0,
        ST_TRACK = 2'd1,
        ST_FAULT = 2'd2
    } dll_state_e;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DN   = 2'd2
    } step_e;

    localparam logic [1:0] PD_EARLY = 2'b01;
    localparam logic [1:0] PD_LATE  = 2'b10;

    typedef struct packed {
        logic valid;
        logic early;
        logic late;
        logic win;
    } cmp_t;

    function automatic cmp_t decode_cmp(input logic v, input logic [1:0] code);
        cmp_t c;
        c.valid = v;
        c.early = v && (code == PD_EARLY);
        c.late  = v && (code == PD_LATE);
        c.win   = v && (code != PD_EARLY) && (code != PD_LATE);
        return c;
    endfunction

endpackage

// File: rtl/dllc_cmp_sel.sv
`timescale 1ns/1ps
module dllc_cmp_sel
    import dllc_pkg::*;
(
    input  logic       fb_sel,
    input  logic       pd_valid,
    input  logic [1:0] code_1x,
    input  logic [1:0] code_2x,
    output cmp_t       cmp
);

    logic [1:0] code_sel;

    always_comb begin
        code_sel = fb_sel ? code_2x : code_1x;
        cmp      = decode_cmp(pd_valid, code_sel);
    end

endmodule

// File: rtl/dllc_tap_reg.sv
`timescale 1ns/1ps
module dllc_tap_reg
    import dllc_pkg::*;
#(
    parameter int TAP_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  step_e            step,
    output logic [TAP_W-1:0] tap
);

    localparam logic [TAP_W-1:0] TAP_MAX = '1;
    localparam logic [TAP_W-1:0] TAP_ONE = {{(TAP_W-1){1'b0}}, 1'b1};

    always_ff @(posedge clk) begin
        if (rst) begin
            tap <= '0;
        end else begin
            case (step)
                STEP_UP: if (tap != TAP_MAX) tap <= tap + TAP_ONE;
                STEP_DN: if (tap != '0)      tap <= tap - TAP_ONE;
                default: ;
            endcase
        end
    end

    // R6: the index never jumps by more than one position per edge
    p_one_step_r6: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((tap == $past(tap)) ||
                         (tap == $past(tap) + TAP_ONE) ||
                         (tap == $past(tap) - TAP_ONE)));

endmodule

// File: rtl/dllc_upd_timer.sv
`timescale 1ns/1ps
module dllc_upd_timer #(
    parameter int INT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             restart,
    input  logic [INT_W-1:0] cfg,
    output logic             due
);

    localparam logic [INT_W-1:0] CNT_ONE = {{(INT_W-1){1'b0}}, 1'b1};

    logic [INT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run || restart) begin
            cnt <= '0;
        end else if (cnt < cfg) begin
            cnt <= cnt + CNT_ONE;
        end
    end

    assign due = run && (cnt >= cfg);

    // R6: an update is only ever taken when the interval has elapsed
    p_restart_when_due_r6: assert property (@(posedge clk) disable iff (rst)
        restart |-> due);

endmodule

// File: rtl/dllc_fsm.sv
`timescale 1ns/1ps
module dllc_fsm
    import dllc_pkg::*;
#(
    parameter int TAP_W    = 8,
    parameter int LOCK_RUN = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  cmp_t             cmp,
    input  logic             due,
    input  logic [TAP_W-1:0] tap,
    output step_e            step,
    output logic             apply,
    output logic             locked,
    output logic             range_err
);

    localparam int               RUN_W    = $clog2(LOCK_RUN + 1);
    localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(LOCK_RUN - 1);
    localparam logic [RUN_W-1:0] RUN_ONE  = RUN_W'(1);
    localparam logic [TAP_W-1:0] TAP_MAX  = '1;
    localparam logic [TAP_W-1:0] TAP_NEAR = TAP_MAX - {{(TAP_W-1){1'b0}}, 1'b1};
    localparam logic [TAP_W-1:0] TAP_LOW  = {{(TAP_W-1){1'b0}}, 1'b1};

    dll_state_e       state;
    logic [RUN_W-1:0] run;
    logic             fault_now;

    always_comb begin
        step      = STEP_HOLD;
        apply     = 1'b0;
        fault_now = 1'b0;
        case (state)
            ST_ACQ: begin
                if (cmp.early && (tap != TAP_MAX))  step = STEP_UP;
                else if (cmp.late && (tap != '0))   step = STEP_DN;
            end
            ST_TRACK: begin
                apply = due && cmp.valid;
                if (apply && cmp.early) begin
                    if (tap != TAP_MAX) step = STEP_UP;
                    fault_now = (tap >= TAP_NEAR);
                end else if (apply && cmp.late) begin
                    if (tap != '0) step = STEP_DN;
                    fault_now = (tap <= TAP_LOW);
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_ACQ;
            run       <= '0;
            locked    <= 1'b0;
            range_err <= 1'b0;
        end else begin
            case (state)
                ST_ACQ: begin
                    if (cmp.early || cmp.late) begin
                        run <= '0;
                    end else if (cmp.win) begin
                        if (run == RUN_LAST) begin
                            state  <= ST_TRACK;
                            locked <= 1'b1;
                            run    <= '0;
                        end else begin
                            run <= run + RUN_ONE;
                        end
                    end
                end
                ST_TRACK: begin
                    if (fault_now) begin
                        state     <= ST_FAULT;
                        locked    <= 1'b0;
                        range_err <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // R5: lock is only reported in the tracking state
    p_lock_only_tracking_r5: assert property (@(posedge clk) disable iff (rst)
        locked |-> (state == ST_TRACK));

    // R8: a range fault is sticky until reset
    p_fault_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FAULT) |=> ((state == ST_FAULT) && range_err && !locked));

    // R8: an error flag never coexists with lock
    p_err_no_lock_r8: assert property (@(posedge clk) disable iff (rst)
        range_err |-> !locked);

    // R4: lock is declared only on a within-window comparison
    p_lock_on_window_r4: assert property (@(posedge clk) disable iff (rst)
        ($rose(locked) && !$past(rst)) |-> $past(cmp.win));

endmodule

// File: rtl/dll_ctrl.sv
`timescale 1ns/1ps
module dll_ctrl
    import dllc_pkg::*;
#(
    parameter int TAP_W    = 8,
    parameter int INT_W    = 16,
    parameter int LOCK_RUN = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fb_sel,
    input  logic             pd_valid,
    input  logic [1:0]       pd_code_1x,
    input  logic [1:0]       pd_code_2x,
    input  logic [INT_W-1:0] cfg_interval,
    output logic [TAP_W-1:0] tap,
    output logic             locked,
    output logic             range_err
);

    cmp_t  cmp;
    step_e step;
    logic  apply;
    logic  upd_due;

    dllc_cmp_sel u_sel (
        .fb_sel   (fb_sel),
        .pd_valid (pd_valid),
        .code_1x  (pd_code_1x),
        .code_2x  (pd_code_2x),
        .cmp      (cmp)
    );

    dllc_fsm #(.TAP_W(TAP_W), .LOCK_RUN(LOCK_RUN)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .cmp       (cmp),
        .due       (upd_due),
        .tap       (tap),
        .step      (step),
        .apply     (apply),
        .locked    (locked),
        .range_err (range_err)
    );

    dllc_upd_timer #(.INT_W(INT_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (locked),
        .restart (apply),
        .cfg     (cfg_interval),
        .due     (upd_due)
    );

    dllc_tap_reg #(.TAP_W(TAP_W)) u_tap (
        .clk  (clk),
        .rst  (rst),
        .step (step),
        .tap  (tap)
    );

    // R7: no tap movement while locked and the interval is still running
    p_hold_between_updates_r7: assert property (@(posedge clk) disable iff (rst)
        (locked && !upd_due) |=> $stable(tap));

endmodule

// File: tb/dll_ctrl_bench.sv
`timescale 1ns/1ps
module dll_ctrl_bench;

    localparam int TAP_PS = 45;
    localparam int WIN_PS = 22;
    localparam int MAXT   = 255;
    localparam int LOCKN  = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fb_sel = 1'b0;
    logic        pd_valid = 1'b0;
    logic [1:0]  c1 = 2'b00;
    logic [1:0]  c2 = 2'b00;
    logic [15:0] cfg = 16'd20;
    logic [7:0]  tap;
    logic        locked;
    logic        range_err;

    always #4 clk = ~clk;

    dll_ctrl u_dll_ctrl (
        .clk          (clk),
        .rst          (rst),
        .fb_sel       (fb_sel),
        .pd_valid     (pd_valid),
        .pd_code_1x   (c1),
        .pd_code_2x   (c2),
        .cfg_interval (cfg),
        .tap          (tap),
        .locked       (locked),
        .range_err    (range_err)
    );

    int need_ps = 0;
    int vld_div = 3;
    int force11 = 0;
    int cyc_n   = 0;
    int checks  = 0;
    int fails   = 0;
    bit done    = 0;

    // behavioural reference: integers only
    int m_tap = 0, m_lock = 0, m_err = 0, m_st = 0, m_run = 0, m_cnt = 0;

    always @(posedge clk) begin
        logic [1:0] s;
        bit e, l, v;
        if (rst) begin
            m_tap = 0; m_lock = 0; m_err = 0; m_st = 0; m_run = 0; m_cnt = 0;
        end else begin
            s = fb_sel ? c2 : c1;
            v = pd_valid;
            e = v && (s == 2'b01);
            l = v && (s == 2'b10);
            if (m_st == 0) begin
                if (v) begin
                    if (e) begin m_run = 0; if (m_tap < MAXT) m_tap++; end
                    else if (l) begin m_run = 0; if (m_tap > 0) m_tap--; end
                    else begin
                        m_run++;
                        if (m_run == LOCKN) begin
                            m_st = 1; m_lock = 1; m_run = 0; m_cnt = 0;
                        end
                    end
                end
            end else if (m_st == 1) begin
                if (m_cnt >= int'(cfg) && v) begin
                    m_cnt = 0;
                    if (e) begin
                        if (m_tap >= MAXT - 1) begin m_st = 2; m_lock = 0; m_err = 1; end
                        if (m_tap < MAXT) m_tap++;
                    end else if (l) begin
                        if (m_tap <= 1) begin m_st = 2; m_lock = 0; m_err = 1; end
                        if (m_tap > 0) m_tap--;
                    end
                end else if (m_cnt < int'(cfg)) begin
                    m_cnt++;
                end
            end
        end
    end

    function automatic logic [1:0] plant(int t);
        int err;
        err = need_ps - t * TAP_PS;
        if (err > WIN_PS)       return 2'b01;
        else if (err < -WIN_PS) return 2'b10;
        else                    return 2'b00;
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0d exp=%0d at cycle %0d", tag, act, exp, cyc_n);
        end
    endtask

    // one cycle: compare against the model at the falling edge, then drive
    task automatic cyc();
        string t;
        logic [1:0] s;
        @(negedge clk);
        cyc_n++;
        t = (m_st == 0) ? "R3 tap" : (m_st == 1) ? "R6 tap" : "R8 tap";
        chk(int'(tap) == m_tap, t, int'(tap), m_tap);
        chk(int'(locked) == m_lock, "R4 locked", int'(locked), m_lock);
        chk(int'(range_err) == m_err, "R8 range_err", int'(range_err), m_err);
        pd_valid = (vld_div != 0) && (cyc_n % vld_div == 0);
        s = plant(int'(tap));
        if (force11 != 0 && (cyc_n % 7 == 0)) s = 2'b11;
        if (fb_sel) begin c2 = s; c1 = 2'($urandom); end
        else        begin c1 = s; c2 = 2'($urandom); end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) cyc();
        rst = 1'b0;
    endtask

    task automatic run_until_lock(int maxc);
        int n = 0;
        while (!locked && n < maxc) begin cyc(); n++; end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 8);
        fails++;
        $display("FAIL R9 watchdog expired act=0 exp=1");
        finish_run();
    end

    initial begin
        int t0;
        do_reset();
        chk(tap == 8'd0, "R1 tap after reset", int'(tap), 0);
        chk(locked == 1'b0, "R1 locked after reset", int'(locked), 0);
        chk(range_err == 1'b0, "R1 range_err after reset", int'(range_err), 0);

        // R2: no valid strobes, early codes present -> nothing moves
        fb_sel = 1'b0; need_ps = 5700; cfg = 16'd20; vld_div = 0;
        repeat (30) cyc();
        chk(tap == 8'd0, "R2 invalid strobes ignored", int'(tap), 0);

        // Scenario 1: 1x feedback, acquisition then tracking
        vld_div = 3;
        repeat (50) cyc();
        chk(locked == 1'b0, "R5 unlocked while acquiring", int'(locked), 0);
        run_until_lock(2000);
        chk(locked == 1'b1, "R4 lock reached", int'(locked), 1);
        chk(tap == 8'd127, "R3 acquired tap 1x", int'(tap), 127);
        need_ps = 5790;
        t0 = int'(tap);
        for (int i = 0; i < 15; i++) begin
            cyc();
            chk(int'(tap) == t0, "R7 hold before interval", int'(tap), t0);
        end
        repeat (100) cyc();
        chk(tap == 8'd129, "R6 tracked drift", int'(tap), 129);
        chk(locked == 1'b1, "R6 still locked", int'(locked), 1);

        // Scenario 2: 2x feedback, drift down to the low limit
        fb_sel = 1'b1; force11 = 1; need_ps = 1700; cfg = 16'd10;
        do_reset();
        run_until_lock(2000);
        chk(locked == 1'b1, "R2 lock on 2x path", int'(locked), 1);
        chk(tap == 8'd38, "R2 acquired tap 2x", int'(tap), 38);
        for (int i = 0; i < 60; i++) begin
            need_ps -= TAP_PS;
            repeat (80) cyc();
            if (range_err) break;
        end
        chk(range_err == 1'b1, "R8 low limit error", int'(range_err), 1);
        chk(locked == 1'b0, "R8 lock dropped", int'(locked), 0);
        chk(tap == 8'd0, "R8 tap at low end", int'(tap), 0);
        need_ps = 1700;
        repeat (60) cyc();
        chk(tap == 8'd0, "R8 frozen after fault", int'(tap), 0);
        chk(locked == 1'b0, "R5 unlocked in fault", int'(locked), 0);
        do_reset();
        run_until_lock(2000);
        chk(locked == 1'b1, "R9 relock after reset", int'(locked), 1);
        chk(tap == 8'd38, "R9 relock tap", int'(tap), 38);
        chk(range_err == 1'b0, "R9 error cleared", int'(range_err), 0);

        // Scenario 3: top limit, zero interval
        fb_sel = 1'b0; force11 = 0; cfg = 16'd0; vld_div = 2; need_ps = 12000;
        do_reset();
        repeat (700) cyc();
        chk(tap == 8'd255, "R3 saturates at top", int'(tap), 255);
        chk(locked == 1'b0, "R5 no lock while saturated", int'(locked), 0);
        chk(range_err == 1'b0, "R3 no error in acquisition", int'(range_err), 0);
        need_ps = 11470;
        run_until_lock(200);
        chk(locked == 1'b1, "R4 lock at top tap", int'(locked), 1);
        need_ps = 11520;
        repeat (10) cyc();
        chk(range_err == 1'b1, "R8 high limit error", int'(range_err), 1);
        chk(locked == 1'b0, "R8 lock dropped at top", int'(locked), 0);
        chk(tap == 8'd255, "R8 tap at high end", int'(tap), 255);

        finish_run();
    end

endmodule